// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller Register Front End

This block is the register front end of a fuse controller sitting on a simple memory-mapped bus with single-cycle writes and combinational reads. Software places a word address, a 16-bit unlock key and an optional word-lock request in a control register. It then writes the data register, and that write starts a program operation. A read-control register starts an automatic read of one to four consecutive fuse words into a read buffer. Setting a reload bit refreshes a shadow copy of the whole array, and the bit clears itself when the copy completes.

The fuse array is a behavioural stub. It is blank after reset, programming can only turn bits from 0 to 1, and every word carries a lock bit. A single sequencer runs one operation at a time. A command that arrives while it is busy is dropped and sets a sticky error flag. Nothing is queued.

Top module: `otp_fe_ctrl`

Bus map (word offsets on `bus_addr`): 0x00 control (read), 0x01 control set alias (write), 0x02 control clear alias (write), 0x03 program data (write), 0x04 read control, 0x05 status, 0x08 + i read buffer word i, 0x20 + i shadow word i.

## Requirements
- R1: After reset, the control, status and read-control registers, every read buffer word and every shadow word read as zero.
- R2: Control layout: [3:0] target word, [4] word-lock request, [5] reload, [31:16] unlock key. A write to 0x01 ORs the written bits into these fields. A write to 0x02 clears the written bits of the address, word-lock and key fields. Bit 5 cannot be cleared through 0x02.
- R3: A write to 0x03 while idle with key 0x3E77 starts a program operation. When it completes, the target word becomes its old value ORed with the written data. No fuse bit ever returns to 0.
- R4: A write to 0x03 while idle with any other key programs nothing and sets the error flag, status bit 1.
- R5: Every write to 0x03 made while idle clears the key and word-lock fields to zero.
- R6: A write to 0x01, 0x02, 0x03 or 0x04 while busy (status bit 0 = 1) is ignored and sets the error flag.
- R7: Status bits 1 (error), 2 (program fail) and 3 (locked) are sticky. Writing 1 to a bit at 0x05 clears it, except in a cycle where the same flag is being set, in which case it stays set.
- R8: Writing bit 5 through 0x01 while idle copies the array into the shadow words. Bit 5 reads 1 while the copy runs and reads 0 once it is done.
- R9: Writing 0x04 with bit 0 = 1 and bits [2:1] = n-1 while idle loads words addr..addr+n-1 into read buffer words 0..n-1 and zeroes the remaining buffer words. Bits [2:1] read back at 0x04.
- R10: A read whose last word lies beyond the last array word sets the error flag and leaves the read buffer unchanged.
- R11: A program with the word-lock bit set locks the target word. A later program to a locked word leaves it unchanged and sets status bit 3.
- R12: A program to a word address at or above the array size changes nothing and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |

## Verification
Software can clear the error flag in the same cycle that a finishing read sets it because the read ran past the end of the array. The bench starts an overrunning read and counts cycles from that command edge. It then places a write-one-to-clear to the status register exactly on the completion edge, and the flag must still read 1 afterwards. A second clear one cycle later must remove the flag, which shows that the first clear was overridden and not simply lost.

// File: rtl/otp_fe_pkg.sv
package otp_fe_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 4;   // width of the target-word field
    localparam int unsigned BUS_AW = 6;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam logic [BUS_AW-1:0] OFS_CTRL   = 6'h00;
    localparam logic [BUS_AW-1:0] OFS_SET    = 6'h01;
    localparam logic [BUS_AW-1:0] OFS_CLR    = 6'h02;
    localparam logic [BUS_AW-1:0] OFS_DATA   = 6'h03;
    localparam logic [BUS_AW-1:0] OFS_RDCTL  = 6'h04;
    localparam logic [BUS_AW-1:0] OFS_STAT   = 6'h05;
    localparam logic [BUS_AW-1:0] OFS_RDBUF  = 6'h08;
    localparam logic [BUS_AW-1:0] OFS_SHADOW = 6'h20;

    typedef struct packed {
        logic [15:0]   key;
        logic [9:0]    rsvd;
        logic          reload;
        logic          wlock;
        logic [AW-1:0] addr;
    } ctrl_t;

    typedef struct packed {
        logic locked;
        logic progfail;
        logic err;
    } flags_t;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_PROG   = 2'd1,
        OP_READ   = 2'd2,
        OP_RELOAD = 2'd3
    } op_e;

    // Registers that start or alter an operation and are refused while busy
    function automatic logic is_guarded(input logic [BUS_AW-1:0] a);
        return (a == OFS_SET) || (a == OFS_CLR) || (a == OFS_DATA) || (a == OFS_RDCTL);
    endfunction

endpackage

// File: rtl/otp_fe_seq.sv
module otp_fe_seq
    import otp_fe_pkg::*;
#(
    parameter int unsigned PROG_CYC   = 8,
    parameter int unsigned READ_CYC   = 3,
    parameter int unsigned RELOAD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  op_e  op_in,
    output logic busy,
    output logic done,
    output op_e  op_cur
);
    localparam int unsigned MAXC = (PROG_CYC > READ_CYC)
                                 ? ((PROG_CYC > RELOAD_CYC) ? PROG_CYC : RELOAD_CYC)
                                 : ((READ_CYC > RELOAD_CYC) ? READ_CYC : RELOAD_CYC);
    localparam int unsigned CW = (MAXC > 1) ? $clog2(MAXC) : 1;

    op_e          op_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] first_cnt;

    always_comb begin
        case (op_in)
            OP_PROG:   first_cnt = CW'(PROG_CYC - 1);
            OP_READ:   first_cnt = CW'(READ_CYC - 1);
            default:   first_cnt = CW'(RELOAD_CYC - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_IDLE;
            cnt_q <= '0;
        end else if (op_q == OP_IDLE) begin
            if (start) begin
                op_q  <= op_in;
                cnt_q <= first_cnt;
            end
        end else if (cnt_q == '0) begin
            op_q <= OP_IDLE;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy   = (op_q != OP_IDLE);
    assign done   = busy && (cnt_q == '0);
    assign op_cur = op_q;

endmodule

// File: rtl/otp_fe_array.sv
module otp_fe_array
    import otp_fe_pkg::*;
#(
    parameter int unsigned NWORDS = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       wr_lock,
    output logic [NWORDS-1:0][DW-1:0]  fuse_o,
    output logic [NWORDS-1:0]          lock_o
);
    for (genvar g = 0; g < NWORDS; g++) begin : g_word
        logic [DW-1:0] word_q;
        logic          lock_q;
        logic          hit;

        assign hit = wr_en && (wr_idx == AW'(g)) && !lock_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                lock_q <= 1'b0;
            end else if (hit) begin
                word_q <= word_q | wr_data;   // fuses only blow, never heal
                lock_q <= wr_lock;
            end
        end

        assign fuse_o[g] = word_q;
        assign lock_o[g] = lock_q;
    end

endmodule

// File: rtl/otp_fe_ctrl.sv
module otp_fe_ctrl
    import otp_fe_pkg::*;
#(
    parameter int unsigned NWORDS     = 12,
    parameter int unsigned RD_MAX     = 4,
    parameter int unsigned PROG_CYC   = 8,
    parameter int unsigned READ_CYC   = 3,
    parameter int unsigned RELOAD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    localparam int unsigned RCW = (RD_MAX > 1) ? $clog2(RD_MAX) : 1;

    ctrl_t                      ctrl_q;
    flags_t                     flags_q;
    logic [RCW-1:0]             rdcnt_q;
    logic [AW-1:0]              pl_addr_q;
    logic [DW-1:0]              pl_data_q;
    logic                       pl_lock_q;
    logic [RCW-1:0]             pl_cnt_q;
    logic [RD_MAX-1:0][DW-1:0]  rdbuf_q;
    logic [NWORDS-1:0][DW-1:0]  shadow_q;

    logic                       seq_busy, seq_done;
    op_e                        seq_op, op_in;
    logic [NWORDS-1:0][DW-1:0]  fuse_w;
    logic [NWORDS-1:0]          lock_w;

    // ---------------- access decode ----------------
    logic  wr_hit, reject, accept;
    logic  set_wr, clr_wr, data_wr, rdctl_wr, stat_wr;
    logic  key_ok, start_prog, start_read, start_reload, start_any;
    ctrl_t wfld;

    assign wfld         = ctrl_t'(bus_wdata);
    assign wr_hit       = bus_sel && bus_wr;
    assign reject       = wr_hit && is_guarded(bus_addr) && seq_busy;
    assign accept       = wr_hit && is_guarded(bus_addr) && !seq_busy;
    assign set_wr       = accept && (bus_addr == OFS_SET);
    assign clr_wr       = accept && (bus_addr == OFS_CLR);
    assign data_wr      = accept && (bus_addr == OFS_DATA);
    assign rdctl_wr     = accept && (bus_addr == OFS_RDCTL);
    assign stat_wr      = wr_hit && (bus_addr == OFS_STAT);
    assign key_ok       = (ctrl_q.key == UNLOCK_KEY);
    assign start_prog   = data_wr && key_ok;
    assign start_read   = rdctl_wr && bus_wdata[0];
    assign start_reload = set_wr && wfld.reload;
    assign start_any    = start_prog || start_read || start_reload;
    assign op_in        = start_prog ? OP_PROG : (start_read ? OP_READ : OP_RELOAD);

    otp_fe_seq #(
        .PROG_CYC  (PROG_CYC),
        .READ_CYC  (READ_CYC),
        .RELOAD_CYC(RELOAD_CYC)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start_any),
        .op_in (op_in),
        .busy  (seq_busy),
        .done  (seq_done),
        .op_cur(seq_op)
    );

    // ---------------- completion decode ----------------
    function automatic logic [DW-1:0] word_at(input logic [NWORDS-1:0][DW-1:0] arr,
                                              input int idx);
        logic [DW-1:0] w;
        w = '0;
        for (int k = 0; k < int'(NWORDS); k++) begin
            if (idx == k) w = arr[k];
        end
        return w;
    endfunction

    function automatic logic lock_at(input logic [NWORDS-1:0] lk, input int idx);
        logic b;
        b = 1'b0;
        for (int k = 0; k < int'(NWORDS); k++) begin
            if (idx == k) b = lk[k];
        end
        return b;
    endfunction

    logic prog_done, read_done, reload_done;
    logic prog_oor, prog_locked, read_over;

    assign prog_done   = seq_done && (seq_op == OP_PROG);
    assign read_done   = seq_done && (seq_op == OP_READ);
    assign reload_done = seq_done && (seq_op == OP_RELOAD);
    assign prog_oor    = (int'(pl_addr_q) >= int'(NWORDS));
    assign prog_locked = lock_at(lock_w, int'(pl_addr_q));
    assign read_over   = (int'(pl_addr_q) + int'(pl_cnt_q)) >= int'(NWORDS);

    otp_fe_array #(.NWORDS(NWORDS)) u_array (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (prog_done && !prog_oor && !prog_locked),
        .wr_idx (pl_addr_q),
        .wr_data(pl_data_q),
        .wr_lock(pl_lock_q),
        .fuse_o (fuse_w),
        .lock_o (lock_w)
    );

    // ---------------- flags: set wins over clear ----------------
    flags_t flag_set, flag_clr;

    always_comb begin
        flag_set.err      = reject || (data_wr && !key_ok) || (read_done && read_over);
        flag_set.progfail = prog_done && prog_oor;
        flag_set.locked   = prog_done && !prog_oor && prog_locked;
        flag_clr          = stat_wr ? flags_t'(bus_wdata[3:1]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    // ---------------- control register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (set_wr) begin
                ctrl_q.addr   <= ctrl_q.addr | wfld.addr;
                ctrl_q.wlock  <= ctrl_q.wlock | wfld.wlock;
                ctrl_q.key    <= ctrl_q.key | wfld.key;
                ctrl_q.reload <= ctrl_q.reload | wfld.reload;
            end
            if (clr_wr) begin
                ctrl_q.addr  <= ctrl_q.addr & ~wfld.addr;
                ctrl_q.wlock <= ctrl_q.wlock & ~wfld.wlock;
                ctrl_q.key   <= ctrl_q.key & ~wfld.key;
            end
            if (data_wr) begin
                ctrl_q.key   <= '0;
                ctrl_q.wlock <= 1'b0;
            end
            if (reload_done) ctrl_q.reload <= 1'b0;
        end
    end

    // ---------------- operation payload, buffers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            pl_addr_q <= '0;
            pl_data_q <= '0;
            pl_lock_q <= 1'b0;
            pl_cnt_q  <= '0;
            rdcnt_q   <= '0;
            rdbuf_q   <= '0;
            shadow_q  <= '0;
        end else begin
            if (start_prog) begin
                pl_addr_q <= ctrl_q.addr;
                pl_data_q <= bus_wdata;
                pl_lock_q <= ctrl_q.wlock;
            end
            if (rdctl_wr) rdcnt_q <= bus_wdata[RCW:1];
            if (start_read) begin
                pl_addr_q <= ctrl_q.addr;
                pl_cnt_q  <= bus_wdata[RCW:1];
            end
            if (read_done && !read_over) begin
                for (int i = 0; i < int'(RD_MAX); i++) begin
                    rdbuf_q[i] <= (i <= int'(pl_cnt_q))
                                ? word_at(fuse_w, int'(pl_addr_q) + i) : '0;
                end
            end
            if (reload_done) shadow_q <= fuse_w;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL)  bus_rdata = ctrl_q;
        if (bus_addr == OFS_STAT)  bus_rdata = DW'({flags_q, seq_busy});
        if (bus_addr == OFS_RDCTL) bus_rdata = DW'({rdcnt_q, 1'b0});
        for (int i = 0; i < int'(RD_MAX); i++) begin
            if (bus_addr == OFS_RDBUF + BUS_AW'(i)) bus_rdata = rdbuf_q[i];
        end
        for (int i = 0; i < int'(NWORDS); i++) begin
            if (bus_addr == OFS_SHADOW + BUS_AW'(i)) bus_rdata = shadow_q[i];
        end
    end

endmodule

// File: rtl/otp_fe_ctrl_chk.sv
module otp_fe_ctrl_chk
    import otp_fe_pkg::*;
#(
    parameter int unsigned NWORDS = 12
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [BUS_AW-1:0]         bus_addr,
    input logic [DW-1:0]             bus_wdata,
    input ctrl_t                     ctrl_q,
    input logic                      busy,
    input logic                      err,
    input logic [NWORDS-1:0]         locks,
    input logic [NWORDS-1:0][DW-1:0] fuses
);
    logic data_idle;
    assign data_idle = bus_sel && bus_wr && (bus_addr == OFS_DATA) && !busy;

    AST_BAD_KEY_ERR: assert property (@(posedge clk) disable iff (rst)
        (data_idle && ctrl_q.key != UNLOCK_KEY) |=> err); // R4

    AST_GOOD_KEY_STARTS: assert property (@(posedge clk) disable iff (rst)
        (data_idle && ctrl_q.key == UNLOCK_KEY) |=> busy); // R3

    AST_KEY_WIPED: assert property (@(posedge clk) disable iff (rst)
        data_idle |=> (ctrl_q.key == 16'h0 && !ctrl_q.wlock)); // R5

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && is_guarded(bus_addr) && busy) |=> err); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err && !(bus_sel && bus_wr && bus_addr == OFS_STAT && bus_wdata[1])) |=> err); // R7

    AST_RELOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.reload |-> busy); // R8

    AST_LOCK_NEVER_DROPS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((locks & $past(locks)) == $past(locks))); // R11

    AST_FUSE_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((fuses & $past(fuses)) == $past(fuses))); // R3

endmodule

bind otp_fe_ctrl otp_fe_ctrl_chk #(.NWORDS(NWORDS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .ctrl_q   (ctrl_q),
    .busy     (seq_busy),
    .err      (flags_q.err),
    .locks    (lock_w),
    .fuses    (fuse_w)
);

// File: tb/otp_fe_ctrl_tb.sv
`timescale 1ns/1ps
module otp_fe_ctrl_tb;
    localparam int NW = 12;
    localparam int RDN = 4;
    localparam int READ_CYC = 3;
    localparam logic [15:0] KEY = 16'h3E77;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int nchk = 0;
    int nerr = 0;
    bit reported = 1'b0;

    logic [31:0] m_fuse [NW];
    logic        m_lock [NW];
    logic [31:0] m_rdbuf [RDN];

    always #5 clk = ~clk;

    otp_fe_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        end
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 64; i++) begin
            rd(6'h05, s);
            if (!s[0]) return;
        end
        chk("busy-timeout", 32'h1, 32'h0);
    endtask

    task automatic chk_stat(input string tag, input bit e, input bit pf, input bit lk);
        logic [31:0] s;
        rd(6'h05, s);
        chk(tag, s, {28'h0, lk, pf, e, 1'b0});
        wr(6'h05, 32'hE);
    endtask

    task automatic set_addr(input logic [3:0] a);
        wr(6'h02, 32'hFFFF_001F);
        wr(6'h01, {28'h0, a});
    endtask

    task automatic do_prog(input logic [3:0] a, input logic [31:0] d, input bit lk, input bit good);
        logic [31:0] c;
        logic [15:0] k;
        bit e, pf, lf;
        k = good ? KEY : (KEY ^ 16'(1 + $urandom_range(0, 254)));
        wr(6'h02, 32'hFFFF_001F);
        wr(6'h01, {k, 10'h0, 1'b0, lk, a});
        wr(6'h03, d);
        e = 0; pf = 0; lf = 0;
        if (!good) e = 1;
        else if (int'(a) >= NW) pf = 1;
        else if (m_lock[a]) lf = 1;
        else begin
            m_fuse[a] = m_fuse[a] | d;
            m_lock[a] = lk;
        end
        rd(6'h00, c);
        chk("R5 key/wlock wiped", {c[31:16], 11'h0, c[4]}, 28'h0);
        wait_idle();
        chk_stat(good ? (pf ? "R12 progfail" : (lf ? "R11 locked" : "R3 program flags")) : "R4 bad key",
                 e, pf, lf);
    endtask

    task automatic chk_rdbuf(input string tag);
        logic [31:0] v;
        for (int i = 0; i < RDN; i++) begin
            rd(6'h08 + 6'(i), v);
            chk(tag, v, m_rdbuf[i]);
        end
    endtask

    task automatic do_read(input logic [3:0] a, input int n);
        bit over;
        set_addr(a);
        wr(6'h04, 32'(((n - 1) << 1) | 1));
        over = (int'(a) + n - 1) >= NW;
        if (!over)
            for (int i = 0; i < RDN; i++) m_rdbuf[i] = (i < n) ? m_fuse[int'(a) + i] : 32'h0;
        wait_idle();
        chk_stat(over ? "R10 overrun err" : "R9 read flags", over, 1'b0, 1'b0);
        chk_rdbuf(over ? "R10 rdbuf kept" : "R9 rdbuf");
    endtask

    task automatic do_reload();
        logic [31:0] c;
        wr(6'h01, 32'h20);
        rd(6'h00, c);
        chk("R8 reload bit set", 32'(c[5]), 32'h1);
        wait_idle();
        rd(6'h00, c);
        chk("R8 reload self-clear", 32'(c[5]), 32'h0);
        for (int i = 0; i < NW; i++) begin
            rd(6'h20 + 6'(i), c);
            chk("R8 shadow", c, m_fuse[i]);
        end
    endtask

    initial begin
        #(2_000_000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        for (int i = 0; i < NW; i++) begin m_fuse[i] = '0; m_lock[i] = 1'b0; end
        for (int i = 0; i < RDN; i++) m_rdbuf[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(6'h05, v); chk("R1 stat", v, 32'h0);
        rd(6'h04, v); chk("R1 rdctl", v, 32'h0);
        rd(6'h08, v); chk("R1 rdbuf", v, 32'h0);
        rd(6'h2B, v); chk("R1 shadow", v, 32'h0);

        // R2 set/clear aliases
        wr(6'h01, 32'h5);        rd(6'h00, v); chk("R2 set", v, 32'h5);
        wr(6'h01, 32'hA5A0_0012); rd(6'h00, v); chk("R2 set merge", v, 32'hA5A0_0017);
        wr(6'h02, 32'hFF00_0025); rd(6'h00, v); chk("R2 clear", v, 32'h00A0_0012);
        wr(6'h02, 32'hFFFF_001F); rd(6'h00, v); chk("R2 clear all", v, 32'h0);

        // R3/R9 basic program then read
        do_prog(4'd1, 32'h0000_00F0, 1'b0, 1'b1);
        do_prog(4'd1, 32'h0000_0F00, 1'b0, 1'b1);
        do_read(4'd0, 3);
        rd(6'h04, v); chk("R9 count readback", v, 32'h4);

        // R4 bad key
        do_prog(4'd3, 32'hFFFF_FFFF, 1'b0, 1'b0);
        do_read(4'd3, 1);

        // R6 access while busy
        set_addr(4'd1);
        wr(6'h01, {KEY, 16'h0});
        wr(6'h03, 32'h0001_0000);
        m_fuse[1] = m_fuse[1] | 32'h0001_0000;
        wr(6'h01, 32'h3);
        wr(6'h04, 32'h1);
        wait_idle();
        rd(6'h00, v); chk("R6 ctrl unchanged", v, 32'h1);
        chk_stat("R6 busy err", 1'b1, 1'b0, 1'b0);
        chk_rdbuf("R6 read ignored");

        // R11 word lock
        do_prog(4'd2, 32'h0000_0011, 1'b1, 1'b1);
        do_prog(4'd2, 32'h0000_0100, 1'b0, 1'b1);
        // R12 out-of-range program
        do_prog(4'd13, 32'h1, 1'b0, 1'b1);
        do_reload();

        // R10 overrun reads
        do_read(4'd11, 2);
        do_read(4'd9, 4);
        do_read(4'd8, 4);

        // R7 clear in the same cycle as an overrun sets the error
        set_addr(4'd11);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h3;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (READ_CYC - 1) @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h05; bus_wdata = 32'h2;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(6'h05, v); chk("R7 set wins over clear", v, 32'h2);
        wr(6'h05, 32'h2);
        rd(6'h05, v); chk("R7 later clear", v, 32'h0);

        // constrained random mix
        for (int it = 0; it < 60; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 5)
                do_prog(4'($urandom_range(0, 13)), $urandom & $urandom,
                        ($urandom_range(0, 5) == 0), ($urandom_range(0, 4) != 0));
            else if (k < 8)
                do_read(4'($urandom_range(0, 11)), $urandom_range(1, 4));
            else
                do_reload();
        end
        do_reload();
        summary();
    end
endmodule